// File: doc/BRIEF.md
# Monitoring Capture and Playback Buffer

This block manages two dual-port monitoring memories that sit beside a per-crossing data path. The raw-sample memory (1024 x 18) keeps one ADC sample for each even sub-tick, four per crossing. The energy memory (1024 x 18) keeps one word per crossing, with the 8-bit EM and 8-bit HD results of a tower pair side by side. Memory addresses come straight from the crossing (tick) number, the sub-tick number and an internal two-bit turn counter. Each memory uses its own bit arrangement, so the raw memory holds one turn at sample resolution and the energy memory holds four turns.

Each memory has its own mode. In record mode it overwrites itself as a circular buffer and the live stream passes through to the output. In playback mode it replays host-loaded words in place of the live stream and is never written by the data path. A save request is sampled on sub-tick 0. It freezes all data-path writes and latches the tick number, so a host can read the frozen contents through the second RAM port without disturbing the data path. A rearm pulse resumes recording.

Top module: `mon_capture_top`

## Requirements
- R1: After reset, `frozen` is 0, `snap_tick` is 0, `host_rvalid` is 0, and `raw_out`, `et_em_out` and `et_hd_out` are 0.
- R2: In raw record mode, while not frozen, each cycle whose sub-tick bit 0 is 0 stores `{8'b0, raw_live}` at raw address `{tick_num, sub_tick[2:1]}`. Cycles with an odd sub-tick store nothing.
- R3: In energy record mode, while not frozen, each cycle with sub-tick 7 stores `{2'b0, et_em_live, et_hd_live}` (EM in bits 15:8, HD in bits 7:0) at energy address `{turn, tick_num}`.
- R4: The turn counter is 0 after reset. It advances by one, wrapping 3 to 0, after each cycle in which `tick_num` is 159 and `sub_tick` is 7.
- R5: In record mode each output equals its live input one cycle later: `raw_out` follows `raw_live`, and `et_em_out`/`et_hd_out` follow the EM/HD inputs.
- R6: In raw playback mode, `raw_out` one cycle later is bits 9:0 of the raw word at `{tick_num, sub_tick[2:1]}`, and the data path writes nothing to the raw memory.
- R7: In energy playback mode, `et_em_out`/`et_hd_out` one cycle later are bits 15:8/7:0 of the energy word at `{turn, tick_num}`, and the data path writes nothing to the energy memory.
- R8: `save_req` is sampled only on sub-tick 0. When it is sampled high while not frozen, `frozen` rises on the next cycle and `snap_tick` takes that cycle's `tick_num`. Neither memory is written by the data path in the sampling cycle or at any time while frozen.
- R9: A save request sampled while frozen is ignored: `frozen` stays 1 and `snap_tick` holds.
- R10: A `host_rearm` pulse while frozen clears `frozen` on the next cycle and recording resumes. A pulse while not frozen changes nothing.
- R11: A host access with `host_en`=1 targets the raw memory when `host_sel`=0 and the energy memory when `host_sel`=1. A write stores `host_wdata` at `host_addr`. A read raises `host_rvalid` on the next cycle with the addressed word on `host_rdata`. Host traffic never stalls the data path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_num | input | 8 | Crossing number, 1..159 |
| sub_tick | input | 3 | Sub-tick number, 0..7 |
| save_req | input | 1 | Save-monitor request, sampled on sub-tick 0 |
| raw_play | input | 1 | 1: raw memory in playback mode |
| et_play | input | 1 | 1: energy memory in playback mode |
| raw_live | input | 10 | Live raw sample |
| et_em_live | input | 8 | Live EM energy |
| et_hd_live | input | 8 | Live HD energy |
| raw_out | output | 10 | Raw stream after record/playback select |
| et_em_out | output | 8 | EM stream after select |
| et_hd_out | output | 8 | HD stream after select |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | Host write (1) or read (0) |
| host_sel | input | 1 | 0 raw memory, 1 energy memory |
| host_addr | input | 10 | Host word address |
| host_wdata | input | 18 | Host write data |
| host_rearm | input | 1 | Clear the frozen state |
| host_rdata | output | 18 | Host read data |
| host_rvalid | output | 1 | Host read data valid |
| frozen | output | 1 | Writes suspended after a save |
| snap_tick | output | 8 | Tick number latched by the save |

## Verification
Every result of this block is due exactly one clock after the inputs that cause it. The pass-through or replayed samples, the rise of `frozen` with its `snap_tick`, the fall of `frozen` after a rearm, and host read data with `host_rvalid` all appear on that next edge. A memory write shows only through a host read issued on a later cycle. The bench's reference model therefore steps once per clock from the inputs applied before the edge and compares every output at the following falling edge. Host readbacks are done only while frozen or in playback, so a host read never meets a data-path write to the same word.

// File: rtl/mon_pkg.sv
package mon_pkg;
  localparam int TICK_W_D  = 8;
  localparam int SUB_W_D   = 3;
  localparam int TURN_W_D  = 2;
  localparam int RAW_W_D   = 10;
  localparam int ET_W_D    = 8;
  localparam int WORD_W_D  = 18;
  localparam int TICK_LAST_D = 159;

  typedef enum logic {
    BUF_RAW = 1'b0,
    BUF_ET  = 1'b1
  } buf_sel_e;
endpackage

// File: rtl/mon_addr_gen.sv
module mon_addr_gen #(
  parameter int TICK_W    = 8,
  parameter int SUB_W     = 3,
  parameter int TURN_W    = 2,
  parameter int TICK_LAST = 159,
  localparam int RAW_AW   = TICK_W + SUB_W - 1,
  localparam int ET_AW    = TURN_W + TICK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] tick_num,
  input  logic [SUB_W-1:0]  sub_tick,
  output logic [RAW_AW-1:0] raw_addr,
  output logic [ET_AW-1:0]  et_addr,
  output logic              raw_slot,
  output logic              et_slot
);
  localparam logic [SUB_W-1:0]  SUB_LAST = {SUB_W{1'b1}};
  localparam logic [TICK_W-1:0] TICK_END = TICK_W'(TICK_LAST);

  logic [TURN_W-1:0] turn_q, turn_d;
  logic              turn_en;

  // Turn advances after the last sub-tick of the last crossing
  assign turn_en = (tick_num == TICK_END) && (sub_tick == SUB_LAST);

  always_comb begin
    turn_d = turn_q;
    if (turn_en) turn_d = turn_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       turn_q <= '0;
    else if (turn_en) turn_q <= turn_d;
  end

  // Raw memory: crossing high, upper sub-tick bits low
  assign raw_addr = {tick_num, sub_tick[SUB_W-1:1]};
  // Energy memory: turn high, crossing low
  assign et_addr  = {turn_q, tick_num};

  assign raw_slot = ~sub_tick[0];
  assign et_slot  = (sub_tick == SUB_LAST);
endmodule

// File: rtl/mon_capture_ctrl.sv
module mon_capture_ctrl #(
  parameter int TICK_W = 8,
  parameter int SUB_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] tick_num,
  input  logic [SUB_W-1:0]  sub_tick,
  input  logic              save_req,
  input  logic              rearm,
  output logic              frozen,
  output logic [TICK_W-1:0] snap_tick,
  output logic              wr_allow
);
  logic              frz_q, frz_d;
  logic [TICK_W-1:0] snap_q, snap_d;
  logic              save_hit;
  logic              snap_en;

  assign save_hit = save_req && (sub_tick == '0) && !frz_q;
  assign snap_en  = save_hit;

  always_comb begin
    frz_d  = frz_q;
    snap_d = snap_q;
    if (frz_q) begin
      if (rearm) frz_d = 1'b0;
    end else if (save_hit) begin
      frz_d  = 1'b1;
      snap_d = tick_num;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frz_q <= 1'b0;
    else        frz_q <= frz_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (snap_en) snap_q <= snap_d;
  end

  // The sampling cycle itself is already excluded from writing
  assign wr_allow  = !frz_q && !save_hit;
  assign frozen    = frz_q;
  assign snap_tick = snap_q;
endmodule

// File: rtl/mon_dpram.sv
module mon_dpram #(
  parameter int AW = 10,
  parameter int DW = 18,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wd,
  output logic [DW-1:0] a_rd,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wd,
  output logic [DW-1:0] b_rd
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we)         mem[a_addr] <= a_wd;
    if (b_en && b_we) mem[b_addr] <= b_wd;
  end

  always_ff @(posedge clk) begin
    a_rd <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    if (b_en && !b_we) b_rd <= mem[b_addr];
  end
endmodule

// File: rtl/mon_capture_top.sv
module mon_capture_top
  import mon_pkg::*;
#(
  parameter int TICK_W    = TICK_W_D,
  parameter int SUB_W     = SUB_W_D,
  parameter int TURN_W    = TURN_W_D,
  parameter int RAW_W     = RAW_W_D,
  parameter int ET_W      = ET_W_D,
  parameter int WORD_W    = WORD_W_D,
  parameter int TICK_LAST = TICK_LAST_D,
  localparam int RAW_AW   = TICK_W + SUB_W - 1,
  localparam int ET_AW    = TURN_W + TICK_W,
  localparam int HOST_AW  = (RAW_AW > ET_AW) ? RAW_AW : ET_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TICK_W-1:0]  tick_num,
  input  logic [SUB_W-1:0]   sub_tick,
  input  logic               save_req,
  input  logic               raw_play,
  input  logic               et_play,
  input  logic [RAW_W-1:0]   raw_live,
  input  logic [ET_W-1:0]    et_em_live,
  input  logic [ET_W-1:0]    et_hd_live,
  output logic [RAW_W-1:0]   raw_out,
  output logic [ET_W-1:0]    et_em_out,
  output logic [ET_W-1:0]    et_hd_out,
  input  logic               host_en,
  input  logic               host_we,
  input  logic               host_sel,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [WORD_W-1:0]  host_wdata,
  input  logic               host_rearm,
  output logic [WORD_W-1:0]  host_rdata,
  output logic               host_rvalid,
  output logic               frozen,
  output logic [TICK_W-1:0]  snap_tick
);
  localparam int RAW_PAD = WORD_W - RAW_W;
  localparam int ET_PAD  = WORD_W - 2 * ET_W;

  logic [RAW_AW-1:0] raw_addr;
  logic [ET_AW-1:0]  et_addr;
  logic              raw_slot, et_slot, wr_allow;
  logic              raw_we, et_we;
  logic [WORD_W-1:0] raw_wd, et_wd, raw_rd_a, et_rd_a, raw_rd_b, et_rd_b;
  logic              raw_hen, et_hen;

  mon_addr_gen #(
    .TICK_W(TICK_W), .SUB_W(SUB_W), .TURN_W(TURN_W), .TICK_LAST(TICK_LAST)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .tick_num(tick_num), .sub_tick(sub_tick),
    .raw_addr(raw_addr), .et_addr(et_addr),
    .raw_slot(raw_slot), .et_slot(et_slot)
  );

  mon_capture_ctrl #(.TICK_W(TICK_W), .SUB_W(SUB_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_num(tick_num), .sub_tick(sub_tick),
    .save_req(save_req), .rearm(host_rearm),
    .frozen(frozen), .snap_tick(snap_tick), .wr_allow(wr_allow)
  );

  // Data-path write enables: record mode, not frozen, in its slot
  assign raw_we = !raw_play && raw_slot && wr_allow;
  assign et_we  = !et_play  && et_slot  && wr_allow;

  generate
    if (RAW_PAD > 0) begin : g_raw_pad
      assign raw_wd = {{RAW_PAD{1'b0}}, raw_live};
    end else begin : g_raw_nopad
      assign raw_wd = raw_live;
    end
    if (ET_PAD > 0) begin : g_et_pad
      assign et_wd = {{ET_PAD{1'b0}}, et_em_live, et_hd_live};
    end else begin : g_et_nopad
      assign et_wd = {et_em_live, et_hd_live};
    end
  endgenerate

  assign raw_hen = host_en && (host_sel == BUF_RAW);
  assign et_hen  = host_en && (host_sel == BUF_ET);

  mon_dpram #(.AW(RAW_AW), .DW(WORD_W)) u_raw_mem (
    .clk(clk),
    .a_we(raw_we), .a_addr(raw_addr), .a_wd(raw_wd), .a_rd(raw_rd_a),
    .b_en(raw_hen), .b_we(host_we), .b_addr(host_addr[RAW_AW-1:0]),
    .b_wd(host_wdata), .b_rd(raw_rd_b)
  );

  mon_dpram #(.AW(ET_AW), .DW(WORD_W)) u_et_mem (
    .clk(clk),
    .a_we(et_we), .a_addr(et_addr), .a_wd(et_wd), .a_rd(et_rd_a),
    .b_en(et_hen), .b_we(host_we), .b_addr(host_addr[ET_AW-1:0]),
    .b_wd(host_wdata), .b_rd(et_rd_b)
  );

  // Live stream staging, aligned with the one-cycle RAM read
  logic [RAW_W-1:0] live_raw_q;
  logic [ET_W-1:0]  live_em_q, live_hd_q;
  logic             raw_play_q, et_play_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_raw_q <= '0;
      live_em_q  <= '0;
      live_hd_q  <= '0;
      raw_play_q <= 1'b0;
      et_play_q  <= 1'b0;
    end else begin
      live_raw_q <= raw_live;
      live_em_q  <= et_em_live;
      live_hd_q  <= et_hd_live;
      raw_play_q <= raw_play;
      et_play_q  <= et_play;
    end
  end

  assign raw_out   = raw_play_q ? raw_rd_a[RAW_W-1:0] : live_raw_q;
  assign et_em_out = et_play_q ? et_rd_a[2*ET_W-1:ET_W] : live_em_q;
  assign et_hd_out = et_play_q ? et_rd_a[ET_W-1:0]      : live_hd_q;

  // Host read return
  logic rvalid_q, rvalid_d, rsel_q, rsel_en;

  assign rvalid_d = host_en && !host_we;
  assign rsel_en  = rvalid_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= rvalid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rsel_q <= 1'b0;
    else if (rsel_en) rsel_q <= host_sel;
  end

  assign host_rvalid = rvalid_q;
  assign host_rdata  = (rsel_q == BUF_ET) ? et_rd_b : raw_rd_b;
endmodule

// File: rtl/mon_capture_chk.sv
module mon_capture_chk #(
  parameter int TICK_W = 8,
  parameter int SUB_W  = 3,
  parameter int RAW_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TICK_W-1:0] tick_num,
  input logic [SUB_W-1:0]  sub_tick,
  input logic              save_req,
  input logic              raw_play,
  input logic [RAW_W-1:0]  raw_live,
  input logic [RAW_W-1:0]  raw_out,
  input logic              host_en,
  input logic              host_we,
  input logic              host_rearm,
  input logic              host_rvalid,
  input logic              frozen,
  input logic [TICK_W-1:0] snap_tick
);
  assert_freeze_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frozen) |-> $past(save_req && (sub_tick == '0)));

  assert_snap_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frozen) |-> (snap_tick == $past(tick_num)));

  assert_hold_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !host_rearm) |=> (frozen && $stable(snap_tick)));

  assert_rearm_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && host_rearm) |=> !frozen);

  assert_read_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && !host_we) |=> host_rvalid);

  assert_no_spurious_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_en && !host_we) |=> !host_rvalid);

  assert_live_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_play |=> (raw_out == $past(raw_live)));
endmodule

bind mon_capture_top mon_capture_chk u_chk (.*);

// File: tb/mon_capture_top_bench.sv
module mon_capture_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  tick_num;
  logic [2:0]  sub_tick;
  logic        save_req, raw_play, et_play;
  logic [9:0]  raw_live;
  logic [7:0]  et_em_live, et_hd_live;
  logic [9:0]  raw_out;
  logic [7:0]  et_em_out, et_hd_out;
  logic        host_en, host_we, host_sel, host_rearm;
  logic [9:0]  host_addr;
  logic [17:0] host_wdata, host_rdata;
  logic        host_rvalid, frozen;
  logic [7:0]  snap_tick;

  always #10 clk = ~clk;

  mon_capture_top u_mon_capture_top (.*);

  int errs = 0;
  int checks = 0;

  // Behavioural reference state
  logic [17:0] raw_m [1024];
  logic [17:0] et_m [1024];
  bit          raw_v [1024];
  bit          et_v [1024];
  int          m_turn = 0;
  bit          m_frozen = 0;
  int          m_snap = 0;
  int          exp_raw = 0, exp_em = 0, exp_hd = 0;
  bit          exp_rv = 0, rd_known = 0;
  int          exp_rd = 0;
  string       rd_tag = "R11";
  int          b_tick = 1, b_sub = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive_stream();
    tick_num   = 8'(b_tick);
    sub_tick   = 3'(b_sub);
    raw_live   = 10'($urandom);
    et_em_live = 8'($urandom);
    et_hd_live = 8'($urandom);
  endtask

  // One clock: model step, edge, compare, advance stimulus
  task automatic cycle();
    int  ra, ea;
    bit  hit;
    ra  = {tick_num, sub_tick[2:1]};
    ea  = (m_turn << 8) | tick_num;
    hit = (sub_tick == 0) && save_req && !m_frozen;
    exp_raw = raw_play ? int'(raw_m[ra][9:0]) : int'(raw_live);
    exp_em  = et_play ? int'(et_m[ea][15:8]) : int'(et_em_live);
    exp_hd  = et_play ? int'(et_m[ea][7:0])  : int'(et_hd_live);
    exp_rv  = host_en && !host_we;
    if (exp_rv) begin
      exp_rd   = host_sel ? int'(et_m[host_addr]) : int'(raw_m[host_addr]);
      rd_known = host_sel ? et_v[host_addr] : raw_v[host_addr];
    end
    if (!raw_play && !m_frozen && !hit && !sub_tick[0]) begin
      raw_m[ra] = {8'b0, raw_live}; raw_v[ra] = 1;
    end
    if (!et_play && !m_frozen && !hit && sub_tick == 7) begin
      et_m[ea] = {2'b0, et_em_live, et_hd_live}; et_v[ea] = 1;
    end
    if (host_en && host_we) begin
      if (host_sel) begin et_m[host_addr] = host_wdata; et_v[host_addr] = 1; end
      else begin raw_m[host_addr] = host_wdata; raw_v[host_addr] = 1; end
    end
    if (m_frozen && host_rearm) m_frozen = 0;
    else if (hit) begin m_frozen = 1; m_snap = tick_num; end
    if (tick_num == 159 && sub_tick == 7) m_turn = (m_turn + 1) % 4;

    @(posedge clk);
    @(negedge clk);

    chk(raw_out == 10'(exp_raw), raw_play ? "R6" : "R5", "raw_out", raw_out, exp_raw);
    chk(et_em_out == 8'(exp_em), et_play ? "R7" : "R5", "et_em_out", et_em_out, exp_em);
    chk(et_hd_out == 8'(exp_hd), et_play ? "R7" : "R5", "et_hd_out", et_hd_out, exp_hd);
    chk(frozen == m_frozen, "R8", "frozen", frozen, m_frozen);
    chk(snap_tick == 8'(m_snap), "R8", "snap_tick", snap_tick, m_snap);
    chk(host_rvalid == exp_rv, "R11", "host_rvalid", host_rvalid, exp_rv);
    if (exp_rv && rd_known)
      chk(host_rdata == 18'(exp_rd), rd_tag, "host_rdata", host_rdata, exp_rd);

    b_sub++;
    if (b_sub == 8) begin
      b_sub = 0;
      b_tick = (b_tick == 159) ? 1 : b_tick + 1;
    end
    drive_stream();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic wait_sub(int s);
    while (b_sub != s) cycle();
  endtask

  task automatic host_acc(bit we, bit sel, int addr, int data);
    host_en = 1; host_we = we; host_sel = sel;
    host_addr = 10'(addr); host_wdata = 18'(data);
    cycle();
    host_en = 0; host_we = 0;
  endtask

  task automatic pulse_save();
    save_req = 1; cycle(); save_req = 0;
  endtask

  task automatic pulse_rearm();
    host_rearm = 1; cycle(); host_rearm = 0;
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int s;
    for (int i = 0; i < 1024; i++) begin
      raw_m[i] = '0; et_m[i] = '0; raw_v[i] = 0; et_v[i] = 0;
    end
    rst_n = 0; save_req = 0; raw_play = 0; et_play = 0;
    host_en = 0; host_we = 0; host_sel = 0; host_rearm = 0;
    host_addr = '0; host_wdata = '0;
    tick_num = 8'd1; sub_tick = 3'd0; raw_live = '0; et_em_live = '0; et_hd_live = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(frozen == 0, "R1", "frozen", frozen, 0);
    chk(snap_tick == 0, "R1", "snap_tick", snap_tick, 0);
    chk(host_rvalid == 0, "R1", "host_rvalid", host_rvalid, 0);
    chk(raw_out == 0, "R1", "raw_out", raw_out, 0);
    chk(et_em_out == 0 && et_hd_out == 0, "R1", "et_out", {et_em_out, et_hd_out}, 0);
    rst_n = 1;
    drive_stream();

    // R5: record pass-through over 1.5 turns; R2/R3/R4 build memory contents
    run(1900);

    // R8: request away from sub-tick 0 is not sampled
    wait_sub(3);
    pulse_save();
    chk(frozen == 0, "R8", "frozen after odd-slot request", frozen, 0);
    // R10: rearm while not frozen has no effect
    pulse_rearm();
    chk(frozen == 0, "R10", "frozen after idle rearm", frozen, 0);

    wait_sub(0);
    pulse_save();
    chk(frozen == 1, "R8", "frozen after save", frozen, 1);
    s = m_snap;
    run(100);
    // R9: second request while frozen ignored
    wait_sub(0);
    pulse_save();
    chk(frozen == 1 && snap_tick == 8'(s), "R9", "snap held", snap_tick, s);
    run(300);

    // R2: raw readback around the snapshot tick, frozen contents
    rd_tag = "R2";
    for (int k = 1; k <= 6; k++)
      for (int q = 0; q < 4; q++)
        host_acc(0, 0, (((s - k + 159 - 1) % 159 + 1) << 2) | q, 0);
    // R3: energy readback for turn 1
    rd_tag = "R3";
    for (int k = 1; k <= 8; k++) host_acc(0, 1, (1 << 8) | k, 0);
    // R4: turn 0 entries from the first turn differ by address
    rd_tag = "R4";
    for (int k = 150; k <= 159; k++) host_acc(0, 1, k, 0);
    for (int k = 1; k <= 4; k++) host_acc(0, 1, (1 << 8) | (159 - k), 0);

    // R10: rearm resumes recording
    pulse_rearm();
    chk(frozen == 0, "R10", "frozen after rearm", frozen, 0);
    run(400);
    wait_sub(0);
    pulse_save();
    s = m_snap;
    rd_tag = "R10";
    for (int k = 1; k <= 3; k++)
      for (int q = 0; q < 4; q++)
        host_acc(0, 0, (((s - k + 159 - 1) % 159 + 1) << 2) | q, 0);
    for (int k = 1; k <= 3; k++)
      host_acc(0, 1, (m_turn << 8) | ((s - k + 159 - 1) % 159 + 1), 0);
    pulse_rearm();

    // R6/R7/R11: load patterns through host port, then replay
    raw_play = 1; et_play = 1;
    rd_tag = "R11";
    for (int a = 0; a < 1024; a++) host_acc(1, 0, a, (a * 37 + 5) & 18'h3ffff);
    for (int a = 0; a < 1024; a++) host_acc(1, 1, a, (a * 91 + 3) & 18'h3ffff);
    for (int a = 0; a < 8; a++) host_acc(0, a[0], a * 100, 0);
    run(1400);
    // R6: playback wrote nothing back; raw word still host value
    rd_tag = "R6";
    host_acc(0, 0, 100, 0);
    rd_tag = "R7";
    host_acc(0, 1, 300, 0);
    raw_play = 0; et_play = 0;
    run(20);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule